// File: doc/BRIEF.md
# Dual-Lane Frame-Synchronized Serial Port

This block moves fixed-length words between a host register interface and two serial data lanes, A and B. Both lanes share one serial clock and one frame-sync input. One direction input sets both lanes to transmit or both to receive. Each lane holds one host-side word buffer, one shift register and one sticky error flag. In transmit direction the flag means underflow. In receive direction it means overflow.

The serial clock and frame sync are sampled in the system clock domain, and their edges are found there. In transmit direction a lane loads its buffer at the start of a word. It then drives one bit per serial rising edge, most significant bit first. In receive direction a lane samples one bit per serial falling edge. On the last bit it moves the finished word into its buffer. With the frame-sync-required input high, every word starts on a frame-sync pulse. With it low, the first pulse starts the stream and the following words start back to back.

The host holds a request until ready goes high. An access to the buffer of the inactive direction is never granted while the port is enabled. Dropping the enable clears the port and releases that access with no effect.

Top module: `dual_lane_serport`

## Requirements
- R1: With reset high, or with `en` low for one clock, both error flags and both buffer-full flags become 0 and `sd_out` reads 0. The status word then reads 0.
- R2: In transmit direction (`dir_tx`=1), a lane drives its W-bit word on `sd_out[lane]`, most significant bit first. Lane A is bit 0 and lane B is bit 1. The first bit appears after the serial rising edge on which `fs` is sampled high, and each later rising edge presents the next bit.
- R3: A host write to the lane A transmit buffer (`h_sel`=0) or lane B transmit buffer (`h_sel`=1) sets that lane's full flag. Loading the buffer into the shifter at the start of a word clears the flag. The status word (`h_sel`=4) reads bit 0 = error A, bit 1 = error B, bit 2 = full A, bit 3 = full B, and all other bits 0.
- R4: With frame sync required (`fs_req`=1), a frame-sync pulse that finds a lane's transmit buffer empty sets that lane's error flag, and that lane sends all zeros for the word.
- R5: With `fs_req`=0 in transmit direction, each word after the first starts on the rising edge right after the previous word's last bit, without a frame-sync pulse. A word start that finds the buffer empty sets the error flag and sends zeros.
- R6: In receive direction, each lane samples `sd_in[lane]` on serial falling edges, most significant bit first, starting with the fall after the frame-sync rising edge. After the W-th fall the word is in the receive buffer (`h_sel`=2 for A, 3 for B) and the full flag is set. In this direction `sd_out` stays 0.
- R7: A received word that completes while the buffer is still full sets that lane's error flag. The buffer then holds the newer word.
- R8: A host read of a receive buffer clears that lane's full flag.
- R9: Error flags are sticky while `en` is high. A host write to the status word has no effect on them.
- R10: While `en` is high, a request to a buffer of the inactive direction keeps `h_ready` low for as long as the request is held. The receive buffers are inactive when `dir_tx`=1, and the transmit buffers are inactive when `dir_tx`=0. Dropping `en` raises `h_ready`, and the access changes no buffer.
- R11: The lanes are independent: an underflow on one lane does not set the other lane's error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low clears the port |
| dir_tx | input | 1 | 1 = both lanes transmit, 0 = both receive |
| fs_req | input | 1 | 1 = a frame-sync pulse starts every word |
| h_req | input | 1 | Host access request, held until ready |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 3 | 0 TX A, 1 TX B, 2 RX A, 3 RX B, 4 status |
| h_wdata | input | W | Host write data |
| h_rdata | output | W | Host read data, valid while ready |
| h_ready | output | 1 | Access granted this cycle |
| sclk | input | 1 | Serial clock, sampled by clk |
| fs | input | 1 | Frame sync, sampled on serial rising edge |
| sd_in | input | 2 | Serial data in, lane B in bit 1 |
| sd_out | output | 2 | Serial data out, lane B in bit 1 |

## Verification
The transmit path is swept over a set of words that includes all zeros, all ones and mixed values on both lanes. This shows whether bit order, the start edge and the empty-on-load behaviour are correct. Lane B is then left empty while lane A is fed, which separates per-lane underflow from a shared flag. The gapless mode is run with one refill and then with no refill, which tells the automatic word boundary apart from the error on a missing word. The receive path is swept the same way. Back-to-back words with no read separate overwrite-newest from keep-oldest. Stalled accesses in both directions are released by clearing the port, which checks both the hang and the absence of side effects.

// File: rtl/serport_pkg.sv
package serport_pkg;

    localparam int NUM_LANES = 2;
    localparam int STAT_BITS = 4;

    typedef enum logic [2:0] {
        SEL_TXA  = 3'd0,
        SEL_TXB  = 3'd1,
        SEL_RXA  = 3'd2,
        SEL_RXB  = 3'd3,
        SEL_STAT = 3'd4
    } hsel_e;

    localparam logic [2:0] TX_BASE = 3'd0;
    localparam logic [2:0] RX_BASE = 3'd2;

    // serial timing strobes shared by both lanes
    typedef struct packed {
        logic rise;    // serial clock rising edge seen this cycle
        logic fall;    // serial clock falling edge seen this cycle
        logic start;   // a word begins on this rising edge
        logic active;  // a word is in flight
        logic done;    // last bit sampled on this falling edge
    } strobe_t;

    // buffer belonging to the direction that is not selected
    function automatic logic sel_blocked(input logic [2:0] s, input logic tx);
        if (tx)
            return (s == SEL_RXA) || (s == SEL_RXB);
        else
            return (s == SEL_TXA) || (s == SEL_TXB);
    endfunction

endpackage

// File: rtl/serport_framer.sv
module serport_framer
    import serport_pkg::*;
#(
    parameter int W = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    fs_req,
    input  logic    sclk,
    input  logic    fs,
    output strobe_t stb
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          sclk_q;
    logic [CW-1:0] cnt;
    logic          active;
    logic          running;
    logic          rise, fall, at_end, start;

    assign rise   = sclk & ~sclk_q;
    assign fall   = ~sclk & sclk_q;
    assign at_end = (cnt == LAST);
    assign start  = en & rise & (fs | (~fs_req & running & active & at_end));

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt     <= '0;
            active  <= 1'b0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= '0;
            active  <= 1'b1;
            running <= 1'b1;
        end else if (rise && active) begin
            if (at_end) active <= 1'b0;
            else        cnt    <= cnt + 1'b1;
        end
    end

    always_comb begin
        stb.rise   = rise;
        stb.fall   = fall;
        stb.start  = start;
        stb.active = active;
        stb.done   = en & fall & active & at_end;
    end

endmodule

// File: rtl/serport_lane.sv
module serport_lane
    import serport_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         dir_tx,
    input  strobe_t      stb,
    input  logic         sd_in,
    input  logic         wr_tx,
    input  logic         rd_rx,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] tx_buf,
    output logic [W-1:0] rx_buf,
    output logic         full,
    output logic         err,
    output logic         sd_out
);
    logic [W-1:0] sh;
    logic [W-1:0] sh_in;

    assign sh_in  = {sh[W-2:0], sd_in};
    assign sd_out = dir_tx & stb.active & sh[W-1];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sh     <= '0;
            tx_buf <= '0;
            rx_buf <= '0;
            full   <= 1'b0;
            err    <= 1'b0;
        end else if (dir_tx) begin
            if (stb.start) begin
                sh <= full ? tx_buf : '0;
                if (!full) err <= 1'b1;
            end else if (stb.rise && stb.active) begin
                sh <= sh << 1;
            end
            if (wr_tx) begin
                tx_buf <= wdata;
                full   <= 1'b1;
            end else if (stb.start) begin
                full   <= 1'b0;
            end
        end else begin
            if (stb.fall && stb.active) sh <= sh_in;
            if (stb.done) begin
                rx_buf <= sh_in;
                full   <= 1'b1;
                if (full && !rd_rx) err <= 1'b1;
            end else if (rd_rx) begin
                full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dual_lane_serport.sv
module dual_lane_serport
    import serport_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         dir_tx,
    input  logic         fs_req,
    input  logic         h_req,
    input  logic         h_we,
    input  logic [2:0]   h_sel,
    input  logic [W-1:0] h_wdata,
    output logic [W-1:0] h_rdata,
    output logic         h_ready,
    input  logic         sclk,
    input  logic         fs,
    input  logic [1:0]   sd_in,
    output logic [1:0]   sd_out
);
    localparam int PAD = W - STAT_BITS;

    strobe_t                          stb;
    logic                             acc;
    logic [NUM_LANES-1:0]             wr_tx, rd_rx, full_v, err_v;
    logic [NUM_LANES-1:0][W-1:0]      tx_buf_v, rx_buf_v;

    assign h_ready = h_req & (~en | ~sel_blocked(h_sel, dir_tx));
    assign acc     = h_ready & en;

    serport_framer #(.W(W)) u_framer (
        .clk(clk), .rst(rst), .en(en), .fs_req(fs_req),
        .sclk(sclk), .fs(fs), .stb(stb)
    );

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign wr_tx[i] = acc & h_we & dir_tx & (h_sel == TX_BASE + 3'(i));
        assign rd_rx[i] = acc & ~h_we & ~dir_tx & (h_sel == RX_BASE + 3'(i));

        serport_lane #(.W(W)) u_lane (
            .clk(clk), .rst(rst), .en(en), .dir_tx(dir_tx), .stb(stb),
            .sd_in(sd_in[i]), .wr_tx(wr_tx[i]), .rd_rx(rd_rx[i]),
            .wdata(h_wdata), .tx_buf(tx_buf_v[i]), .rx_buf(rx_buf_v[i]),
            .full(full_v[i]), .err(err_v[i]), .sd_out(sd_out[i])
        );
    end

    always_comb begin
        h_rdata = '0;
        if (acc && !h_we) begin
            case (h_sel)
                SEL_TXA:  h_rdata = tx_buf_v[0];
                SEL_TXB:  h_rdata = tx_buf_v[1];
                SEL_RXA:  h_rdata = rx_buf_v[0];
                SEL_RXB:  h_rdata = rx_buf_v[1];
                SEL_STAT: h_rdata = {{PAD{1'b0}}, full_v, err_v};
                default:  h_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dual_lane_serport_chk.sv
module dual_lane_serport_chk #(
    parameter int W = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       dir_tx,
    input logic       h_req,
    input logic       h_we,
    input logic [2:0] h_sel,
    input logic       h_ready,
    input logic [1:0] sd_out,
    input logic [1:0] err_v,
    input logic [1:0] full_v
);
    logic wrong_dir;
    assign wrong_dir = dir_tx ? (h_sel == 3'd2 || h_sel == 3'd3)
                              : (h_sel == 3'd0 || h_sel == 3'd1);

    // R10: inactive buffer never granted while enabled
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (en && h_req && wrong_dir) |-> !h_ready);

    // R10: clearing the port releases any request
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        (!en && h_req) |-> h_ready);

    // R1: a cycle with enable low empties and clears every lane
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        !en |=> (err_v == 2'b00 && full_v == 2'b00));

    // R9: error flags never drop while enabled
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        en |=> ((err_v & $past(err_v)) == $past(err_v)));

    // R6: outputs quiet in receive direction
    a_r6_rx_quiet: assert property (@(posedge clk) disable iff (rst)
        !dir_tx |-> (sd_out == 2'b00));

    // R3: accepted write to transmit buffer A leaves it full
    a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
        (en && h_req && h_ready && h_we && dir_tx && h_sel == 3'd0) |=> full_v[0]);

endmodule

bind dual_lane_serport dual_lane_serport_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .dir_tx(dir_tx), .h_req(h_req),
    .h_we(h_we), .h_sel(h_sel), .h_ready(h_ready), .sd_out(sd_out),
    .err_v(err_v), .full_v(full_v)
);

// File: tb/dual_lane_serport_tb.sv
module dual_lane_serport_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0, dir_tx = 1'b1, fs_req = 1'b1;
    logic         h_req = 1'b0, h_we = 1'b0;
    logic [2:0]   h_sel = 3'd0;
    logic [W-1:0] h_wdata = '0;
    logic [W-1:0] h_rdata;
    logic         h_ready;
    logic         sclk = 1'b0, fs = 1'b0;
    logic [1:0]   sd_in = 2'b00;
    logic [1:0]   sd_out;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dual_lane_serport #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .dir_tx(dir_tx), .fs_req(fs_req),
        .h_req(h_req), .h_we(h_we), .h_sel(h_sel), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_ready(h_ready), .sclk(sclk), .fs(fs),
        .sd_in(sd_in), .sd_out(sd_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host(input logic we, input logic [2:0] sel, input logic [W-1:0] wd,
                        output logic [W-1:0] rd);
        int n = 0;
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_sel = sel; h_wdata = wd;
        #1;
        while (!h_ready && n < 20) begin
            @(negedge clk); #1; n++;
        end
        if (!h_ready) chk(0, "host access granted", 32'(n), 32'd0);
        rd = h_rdata;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic stat(output logic [3:0] s);
        logic [W-1:0] r;
        host(1'b0, 3'd4, '0, r);
        s = r[3:0];
    endtask

    task automatic sbit(input logic fsv, input logic [1:0] din, output logic [1:0] dout);
        @(negedge clk);
        sclk = 1'b1; fs = fsv; sd_in = din;
        repeat (4) @(negedge clk);
        sclk = 1'b0; fs = 1'b0;
        repeat (3) @(negedge clk);
        dout = sd_out;
    endtask

    task automatic frame(input logic fsv, input logic [W-1:0] ia, input logic [W-1:0] ib,
                         output logic [W-1:0] oa, output logic [W-1:0] ob);
        logic [1:0] d;
        for (int i = 0; i < W; i++) begin
            sbit(i == 0 ? fsv : 1'b0, {ib[W-1-i], ia[W-1-i]}, d);
            oa[W-1-i] = d[0];
            ob[W-1-i] = d[1];
        end
    endtask

    task automatic clear_port();
        @(negedge clk); en = 1'b0;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    function automatic logic [W-1:0] pat(input int k);
        if (k == 0) return '0;
        if (k == 1) return '1;
        return W'(k * 16'h3B1D) ^ W'(16'h5A0F);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]   s;
        logic [W-1:0] r, oa, ob, wa, wb;
        logic [1:0]   d;

        repeat (3) @(negedge clk);
        rst = 1'b0; en = 1'b1;
        #1;
        chk(sd_out == 2'b00, "R1 reset sd_out", 32'(sd_out), 0);
        stat(s);
        chk(s == 4'b0000, "R1 reset status", 32'(s), 0);

        // transmit sweep, frame sync per word
        for (int k = 0; k < 6; k++) begin
            wa = pat(k); wb = ~pat(k + 3);
            host(1'b1, 3'd0, wa, r);
            host(1'b1, 3'd1, wb, r);
            stat(s);
            chk(s == 4'b1100, "R3 both full after write", 32'(s), 32'hC);
            frame(1'b1, '0, '0, oa, ob);
            chk(oa == wa, "R2 lane A word", 32'(oa), 32'(wa));
            chk(ob == wb, "R2 lane B word", 32'(ob), 32'(wb));
            stat(s);
            chk(s == 4'b0000, "R3 empty after load", 32'(s), 0);
        end

        // underflow on lane B only
        wa = 16'hC3A5;
        host(1'b1, 3'd0, wa, r);
        frame(1'b1, '0, '0, oa, ob);
        chk(ob == '0, "R4 underflow sends zeros", 32'(ob), 0);
        chk(oa == wa, "R11 lane A unaffected", 32'(oa), 32'(wa));
        stat(s);
        chk(s == 4'b0010, "R4 R11 error B only", 32'(s), 32'h2);
        host(1'b1, 3'd4, '1, r);
        stat(s);
        chk(s == 4'b0010, "R9 status write ignored", 32'(s), 32'h2);
        frame(1'b1, '0, '0, oa, ob);
        stat(s);
        chk(s == 4'b0011, "R4 A now underflows too", 32'(s), 32'h3);
        clear_port();
        #1;
        stat(s);
        chk(s == 4'b0000, "R1 clear status", 32'(s), 0);

        // gapless mode
        fs_req = 1'b0;
        host(1'b1, 3'd0, 16'h1234, r);
        host(1'b1, 3'd1, 16'hFEDC, r);
        sbit(1'b1, 2'b00, d);
        oa = '0; ob = '0;
        oa[W-1] = d[0]; ob[W-1] = d[1];
        host(1'b1, 3'd0, 16'h0F0F, r);
        host(1'b1, 3'd1, 16'h8001, r);
        for (int i = 1; i < W; i++) begin
            sbit(1'b0, 2'b00, d);
            oa[W-1-i] = d[0]; ob[W-1-i] = d[1];
        end
        chk(oa == 16'h1234, "R5 first gapless word A", 32'(oa), 32'h1234);
        chk(ob == 16'hFEDC, "R5 first gapless word B", 32'(ob), 32'hFEDC);
        frame(1'b0, '0, '0, oa, ob);
        chk(oa == 16'h0F0F, "R5 auto second word A", 32'(oa), 32'h0F0F);
        chk(ob == 16'h8001, "R5 auto second word B", 32'(ob), 32'h8001);
        stat(s);
        chk(s == 4'b0000, "R5 no error when refilled", 32'(s), 0);
        frame(1'b0, '0, '0, oa, ob);
        chk({oa, ob} == '0, "R5 empty boundary zeros", 32'(oa | ob), 0);
        stat(s);
        chk(s == 4'b0011, "R5 empty boundary error", 32'(s), 32'h3);
        clear_port();

        // receive sweep
        fs_req = 1'b1; dir_tx = 1'b0;
        for (int k = 0; k < 6; k++) begin
            wa = pat(k + 1); wb = pat(k) ^ 16'h00FF;
            frame(1'b1, wa, wb, oa, ob);
            chk({oa, ob} == '0, "R6 outputs quiet", 32'(oa | ob), 0);
            stat(s);
            chk(s == 4'b1100, "R6 both full after word", 32'(s), 32'hC);
            host(1'b0, 3'd2, '0, r);
            chk(r == wa, "R6 lane A received", 32'(r), 32'(wa));
            host(1'b0, 3'd3, '0, r);
            chk(r == wb, "R6 lane B received", 32'(r), 32'(wb));
            stat(s);
            chk(s == 4'b0000, "R8 read empties", 32'(s), 0);
        end

        // overflow keeps newest
        frame(1'b1, 16'hAAAA, 16'h5555, oa, ob);
        frame(1'b1, 16'h1357, 16'h2468, oa, ob);
        stat(s);
        chk(s == 4'b1111, "R7 overflow both lanes", 32'(s), 32'hF);
        host(1'b0, 3'd2, '0, r);
        chk(r == 16'h1357, "R7 newest word kept A", 32'(r), 32'h1357);
        host(1'b0, 3'd3, '0, r);
        chk(r == 16'h2468, "R7 newest word kept B", 32'(r), 32'h2468);
        clear_port();

        // stall on inactive transmit buffer while receiving
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_sel = 3'd0; h_wdata = 16'hBEEF;
        begin
            int seen = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk); #1;
                if (h_ready) seen++;
            end
            chk(seen == 0, "R10 stall holds", 32'(seen), 0);
        end
        en = 1'b0;
        #1;
        chk(h_ready == 1'b1, "R10 clear releases", 32'(h_ready), 1);
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
        en = 1'b1; dir_tx = 1'b1;
        stat(s);
        chk(s == 4'b0000, "R10 stalled write no effect", 32'(s), 0);

        // stall on inactive receive buffer while transmitting
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b0; h_sel = 3'd3;
        repeat (10) @(negedge clk);
        #1;
        chk(h_ready == 1'b0, "R10 read stall in transmit", 32'(h_ready), 0);
        en = 1'b0;
        #1;
        chk(h_ready == 1'b1, "R10 read released", 32'(h_ready), 1);
        @(negedge clk);
        h_req = 1'b0; en = 1'b1;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule